// File: doc/BRIEF.md
# Graphics RAM Command Decoder with Bank Tracking

This block sits at the command pins of a two-bank synchronous graphics RAM. It samples the row strobe, column strobe, write strobe and special-function strobe, together with the bank select and the address, on every rising clock edge. Each sample is turned into one of six commands. The block keeps a small state machine per bank that follows the row from idle, through the activate-to-access delay, to open, and on to closing after a read with auto-precharge. A command that breaks a timing or state rule is discarded and flagged.

The burst length in cycles, a full-page flag, the activate-to-access delay and the precharge time are inputs. The surrounding controller programs them and holds them steady. After a read with auto-precharge, the block stays busy for the precharge time plus the burst length and lets no command through. When full-page bursts are set, the auto-precharge request is dropped and the read goes ahead as a plain read.

Each bank state machine has four states: `BK_IDLE`, `BK_OPENING`, `BK_OPEN` and `BK_CLOSING`.
- `BK_IDLE` goes to `BK_OPEN` on an activate when the delay is 0 or 1, and to `BK_OPENING` on an activate when the delay is longer.
- `BK_OPENING` goes to `BK_OPEN` when its counter runs out, and to `BK_IDLE` on a precharge.
- `BK_OPEN` goes to `BK_IDLE` on a precharge, and to `BK_CLOSING` on a read with auto-precharge.
- `BK_CLOSING` goes to `BK_IDLE` when its countdown ends.

Top module: `sgram_cmd_decoder`

## Requirements
- R1: Pin levels are written row/col/write strobe, and the special-function strobe must be low for every command except no-operation. The commands decode as follows:
  - Activate is L/H/H.
  - Precharge is L/H/L.
  - Read is H/L/H with address bit 8 low. Read with auto-precharge is the same pattern with address bit 8 high.
  - Write is H/L/L with address bit 8 low.
  - Any other pattern is treated as no-operation and gives no violation and no state change. This covers H/H/H, a special-function strobe that is high, and a write with bit 8 high.
- R2: `cmd_out` carries the accepted command: NOP=0, ACT=1, RD=2, RDA=3, WR=4, PRE=5. Both `cmd_out` and `violation` appear in the cycle after the edge that sampled the pins.
- R3: A read with auto-precharge to an open bank drives `bank_open` low for that bank from the next cycle. `busy` is then high for exactly `trp_cycles + burst_cycles` cycles, after which the bank is idle.
- R4: While `busy` is high, any command other than no-operation raises `violation` for one cycle, gives `cmd_out` = NOP, and changes no bank state. A no-operation raises no violation.
- R5: With `full_page` high, a read with auto-precharge is reported as RD, the bank stays open, and `busy` stays low.
- R6: A read or write to a bank is accepted only `trcd_cycles` edges or more after its activate. A value of 0 or 1 allows the access at the very next edge. An earlier access raises `violation`.
- R7: A read or write to an idle bank raises `violation`. A precharge to an idle bank gives NOP with no violation.
- R8: An activate to a bank that is not idle raises `violation`. A precharge to an opening or open bank closes it, and `cmd_out` gives PRE.
- R9: After reset both banks are idle, and `busy`, `violation` and `cmd_out` are all zero.
- R10: The two banks are tracked independently: one bank can be activated, accessed or precharged while the other is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_strobe | input | 1 | Row strobe pin level |
| col_strobe | input | 1 | Column strobe pin level |
| write_strobe | input | 1 | Write strobe pin level |
| func_strobe | input | 1 | Special-function strobe pin level |
| bank_sel | input | 1 | Bank select |
| addr | input | 11 | Address; bit 8 requests auto-precharge |
| burst_cycles | input | 4 | Programmed burst length in cycles |
| full_page | input | 1 | High when full-page bursts are programmed |
| trcd_cycles | input | 4 | Activate-to-access delay in cycles |
| trp_cycles | input | 4 | Precharge time in cycles |
| cmd_out | output | 3 | Accepted command code |
| bank_open | output | 2 | Per-bank open flag (opening or open) |
| busy | output | 1 | Auto-precharge lockout in progress |
| violation | output | 1 | One-cycle flag for a discarded command |

## Verification
Directed sequences walk each bank through every state. They place accesses one edge before and exactly at the activate-to-access boundary, and they count the busy window after a read with auto-precharge, with and without full-page bursts. Seeded random pin patterns then mix legal commands, undecodable patterns, accesses to the wrong bank and commands inside the lockout. The timing settings change between rounds, which separates lockout errors from delay errors and from state errors. Every cycle is compared against a bench model built from the requirements.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_RDA = 3'd3,
        CMD_WR  = 3'd4,
        CMD_PRE = 3'd5
    } sgc_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPENING = 2'd1,
        BK_OPEN    = 2'd2,
        BK_CLOSING = 2'd3
    } sgc_bank_e;

endpackage

// File: rtl/sgc_cmd_decode.sv
module sgc_cmd_decode
    import sgc_pkg::*;
(
    input  logic     row_lvl,
    input  logic     col_lvl,
    input  logic     wr_lvl,
    input  logic     fn_lvl,
    input  logic     ap_lvl,
    output sgc_cmd_e cmd_o
);

    // R1: pattern map, pins given as row/col/write levels
    always_comb begin
        cmd_o = CMD_NOP;
        unique case ({row_lvl, col_lvl, wr_lvl})
            3'b011:  cmd_o = fn_lvl ? CMD_NOP : CMD_ACT;
            3'b010:  cmd_o = fn_lvl ? CMD_NOP : CMD_PRE;
            3'b101: begin
                if (!fn_lvl) cmd_o = ap_lvl ? CMD_RDA : CMD_RD;
            end
            3'b100: begin
                if (!fn_lvl && !ap_lvl) cmd_o = CMD_WR;
            end
            default: cmd_o = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sgc_bank_fsm.sv
module sgc_bank_fsm
    import sgc_pkg::*;
#(
    parameter int TW  = 4,
    parameter int BLW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_i,
    input  logic           pre_i,
    input  logic           rda_i,
    input  logic [TW-1:0]  trcd_i,
    input  logic [TW-1:0]  trp_i,
    input  logic [BLW-1:0] bl_i,
    output sgc_bank_e      state_o
);

    localparam int CW = ((TW > BLW) ? TW : BLW) + 1;

    sgc_bank_e     st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_i) begin
                    if (trcd_i <= TW'(1)) begin
                        st_n = BK_OPEN;
                    end else begin
                        st_n  = BK_OPENING;
                        cnt_n = CW'(trcd_i) - CW'(1);
                    end
                end
            end
            BK_OPENING: begin
                if (pre_i)                 st_n = BK_IDLE;
                else if (cnt_q <= CW'(1))  st_n = BK_OPEN;
                else                       cnt_n = cnt_q - CW'(1);
            end
            BK_OPEN: begin
                if (pre_i) begin
                    st_n = BK_IDLE;
                end else if (rda_i) begin
                    st_n  = BK_CLOSING;
                    cnt_n = CW'(trp_i) + CW'(bl_i);
                end
            end
            BK_CLOSING: begin
                if (cnt_q <= CW'(1)) st_n = BK_IDLE;
                else                 cnt_n = cnt_q - CW'(1);
            end
            default: st_n = BK_IDLE;
        endcase
    end

    assign state_o = st_q;

endmodule

// File: rtl/sgram_cmd_decoder.sv
module sgram_cmd_decoder
    import sgc_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int AW     = 11,
    parameter int AP_BIT = 8,
    parameter int TW     = 4,
    parameter int BLW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_strobe,
    input  logic             col_strobe,
    input  logic             write_strobe,
    input  logic             func_strobe,
    input  logic             bank_sel,
    input  logic [AW-1:0]    addr,
    input  logic [BLW-1:0]   burst_cycles,
    input  logic             full_page,
    input  logic [TW-1:0]    trcd_cycles,
    input  logic [TW-1:0]    trp_cycles,
    output logic [2:0]       cmd_out,
    output logic [NBANK-1:0] bank_open,
    output logic             busy,
    output logic             violation
);

    sgc_cmd_e   dec_cmd, acc_cmd, cmd_q;
    logic       bad_cmd, viol_q;
    sgc_bank_e  bank_st [NBANK];
    logic [NBANK-1:0] bank_closing;
    logic [NBANK-1:0] act_v, pre_v, rda_v;
    logic       lock;
    sgc_bank_e  tgt_st;
    logic       unused_addr;

    assign unused_addr = ^{addr[AW-1:AP_BIT+1], addr[AP_BIT-1:0]};

    sgc_cmd_decode u_dec (
        .row_lvl (row_strobe),
        .col_lvl (col_strobe),
        .wr_lvl  (write_strobe),
        .fn_lvl  (func_strobe),
        .ap_lvl  (addr[AP_BIT]),
        .cmd_o   (dec_cmd)
    );

    assign lock   = |bank_closing;
    assign tgt_st = bank_st[bank_sel];

    // acceptance rules: R4 lockout, R5 full page, R6/R7/R8 bank state
    always_comb begin
        acc_cmd = CMD_NOP;
        bad_cmd = 1'b0;
        unique case (dec_cmd)
            CMD_NOP: acc_cmd = CMD_NOP;
            CMD_ACT: begin
                if (lock || tgt_st != BK_IDLE) bad_cmd = 1'b1;
                else                           acc_cmd = CMD_ACT;
            end
            CMD_RD, CMD_WR, CMD_RDA: begin
                if (lock || tgt_st != BK_OPEN) bad_cmd = 1'b1;
                else if (dec_cmd == CMD_RDA && full_page) acc_cmd = CMD_RD;
                else acc_cmd = dec_cmd;
            end
            CMD_PRE: begin
                if (lock)                   bad_cmd = 1'b1;
                else if (tgt_st == BK_IDLE) acc_cmd = CMD_NOP;
                else                        acc_cmd = CMD_PRE;
            end
            default: acc_cmd = CMD_NOP;
        endcase
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic hit;
            assign hit      = (bank_sel == b[0]);
            assign act_v[b] = hit && (acc_cmd == CMD_ACT);
            assign pre_v[b] = hit && (acc_cmd == CMD_PRE);
            assign rda_v[b] = hit && (acc_cmd == CMD_RDA);

            sgc_bank_fsm #(.TW(TW), .BLW(BLW)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .act_i   (act_v[b]),
                .pre_i   (pre_v[b]),
                .rda_i   (rda_v[b]),
                .trcd_i  (trcd_cycles),
                .trp_i   (trp_cycles),
                .bl_i    (burst_cycles),
                .state_o (bank_st[b])
            );

            assign bank_closing[b] = (bank_st[b] == BK_CLOSING);
            assign bank_open[b]    = (bank_st[b] == BK_OPENING) ||
                                     (bank_st[b] == BK_OPEN);
        end
    endgenerate

    // registered outputs (R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            viol_q <= 1'b0;
        end else begin
            cmd_q  <= acc_cmd;
            viol_q <= bad_cmd;
        end
    end

    assign cmd_out   = cmd_q;
    assign violation = viol_q;
    assign busy      = lock;

endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
    parameter int NBANK = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full_page,
    input logic [2:0]       cmd_out,
    input logic [NBANK-1:0] bank_open,
    input logic             busy,
    input logic             violation,
    input logic [NBANK-1:0] bank_closing
);

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cmd_out == 3'd0)); // R4

    AST_VIOL_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (cmd_out == 3'd0)); // R4

    AST_SINGLE_CLOSING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_closing)); // R3

    AST_RDA_STARTS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 3'd3) |-> busy); // R3

    AST_FULLPAGE_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 3'd3) |-> !$past(full_page)); // R5

    AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 3'd2 || cmd_out == 3'd3 || cmd_out == 3'd4)
            |-> ($past(bank_open) != '0)); // R6

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 3'd5) |-> (bank_open != $past(bank_open))); // R8

endmodule

bind sgram_cmd_decoder sgc_checker #(.NBANK(NBANK)) u_sgc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .full_page    (full_page),
    .cmd_out      (cmd_out),
    .bank_open    (bank_open),
    .busy         (busy),
    .violation    (violation),
    .bank_closing (bank_closing)
);

// File: tb/test_sgram_cmd_decoder.sv
module test_sgram_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_strobe = 1'b1, col_strobe = 1'b1, write_strobe = 1'b1;
    logic        func_strobe = 1'b0, bank_sel = 1'b0;
    logic [10:0] addr = '0;
    logic [3:0]  burst_cycles = 4'd4;
    logic        full_page = 1'b0;
    logic [3:0]  trcd_cycles = 4'd2, trp_cycles = 4'd2;
    logic [2:0]  cmd_out;
    logic [1:0]  bank_open;
    logic        busy, violation;

    int n_chk = 0, n_bad = 0;
    int m_st [2];   // 0 idle, 1 opening, 2 open, 3 closing
    int m_cnt [2];
    int e_cmd, e_viol;
    string e_tag;
    bit done = 0;

    always #5 clk = ~clk;

    sgram_cmd_decoder i_sgram_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .row_strobe(row_strobe), .col_strobe(col_strobe),
        .write_strobe(write_strobe), .func_strobe(func_strobe), .bank_sel(bank_sel),
        .addr(addr), .burst_cycles(burst_cycles), .full_page(full_page),
        .trcd_cycles(trcd_cycles), .trp_cycles(trp_cycles), .cmd_out(cmd_out),
        .bank_open(bank_open), .busy(busy), .violation(violation)
    );

    // R1 pattern table as given in the requirement
    function automatic int pin_decode(logic r, logic c, logic w, logic f, logic a8);
        if (r && c && w) return 0;
        if (f) return 0;
        if (!r && c && w) return 1;
        if (!r && c && !w) return 5;
        if (r && !c && w) return a8 ? 3 : 2;
        if (r && !c && !w && !a8) return 4;
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int d = pin_decode(row_strobe, col_strobe, write_strobe, func_strobe, addr[8]);
        int b = int'(bank_sel);
        bit lock = (m_st[0] == 3) || (m_st[1] == 3);
        e_cmd = 0; e_viol = 0;
        e_tag = (d == 0) ? "R1" : "R2";
        if (d != 0 && lock) begin
            e_viol = 1; e_tag = "R4";
        end else if (d == 1) begin
            if (m_st[b] != 0) begin e_viol = 1; e_tag = "R8"; end
            else begin e_cmd = 1; e_tag = "R10"; end
        end else if (d == 2 || d == 3 || d == 4) begin
            if (m_st[b] == 0) begin e_viol = 1; e_tag = "R7"; end
            else if (m_st[b] == 1) begin e_viol = 1; e_tag = "R6"; end
            else if (d == 3 && full_page) begin e_cmd = 2; e_tag = "R5"; end
            else begin e_cmd = d; if (d == 3) e_tag = "R3"; end
        end else if (d == 5) begin
            if (m_st[b] == 0) e_tag = "R7";
            else begin e_cmd = 5; e_tag = "R8"; end
        end
        for (int k = 0; k < 2; k++) begin
            bit hit = (k == b);
            case (m_st[k])
                0: if (hit && e_cmd == 1) begin
                       if (trcd_cycles <= 1) m_st[k] = 2;
                       else begin m_st[k] = 1; m_cnt[k] = int'(trcd_cycles) - 1; end
                   end
                1: if (hit && e_cmd == 5) m_st[k] = 0;
                   else if (m_cnt[k] <= 1) m_st[k] = 2;
                   else m_cnt[k]--;
                2: if (hit && e_cmd == 5) m_st[k] = 0;
                   else if (hit && e_cmd == 3) begin
                       m_st[k] = 3; m_cnt[k] = int'(trp_cycles) + int'(burst_cycles);
                   end
                default: if (m_cnt[k] <= 1) m_st[k] = 0; else m_cnt[k]--;
            endcase
        end
    endtask

    task automatic cycle(logic [2:0] rcw, logic f, logic b, logic a8);
        {row_strobe, col_strobe, write_strobe} = rcw;
        func_strobe = f;
        bank_sel = b;
        addr = {2'($urandom), a8, 8'($urandom)};
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(e_tag, "cmd_out", int'(cmd_out), e_cmd);
        check(e_tag, "violation", int'(violation), e_viol);
        check(e_tag, "bank_open[0]", int'(bank_open[0]), int'(m_st[0] == 1 || m_st[0] == 2));
        check(e_tag, "bank_open[1]", int'(bank_open[1]), int'(m_st[1] == 1 || m_st[1] == 2));
        check(e_tag, "busy", int'(busy), int'(m_st[0] == 3 || m_st[1] == 3));
    endtask

    localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_PRE = 3'b010,
                           P_RD = 3'b101, P_WR = 3'b100;

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9", "cmd_out", int'(cmd_out), 0);
        check("R9", "violation", int'(violation), 0);
        check("R9", "bank_open", int'(bank_open), 0);
        check("R9", "busy", int'(busy), 0);

        // R7: access and precharge to idle bank
        cycle(P_RD, 0, 0, 0);
        cycle(P_PRE, 0, 0, 0);
        // R6: access one edge early, then at the boundary (trcd=2)
        cycle(P_ACT, 0, 0, 0);
        cycle(P_RD, 0, 0, 0);
        cycle(P_RD, 0, 0, 0);
        // R8 / R10: activate to open bank, then other bank
        cycle(P_ACT, 0, 0, 0);
        cycle(P_ACT, 0, 1, 0);
        // R1: special-function high and write with bit 8 high
        cycle(P_RD, 1, 0, 0);
        cycle(P_WR, 0, 0, 1);
        cycle(P_WR, 0, 0, 0);
        // R3 / R4: auto-precharge window of trp+bl = 6
        cycle(P_RD, 0, 0, 1);
        cycle(P_ACT, 0, 1, 0);
        cycle(P_PRE, 0, 1, 0);
        repeat (3) cycle(P_NOP, 0, 0, 0);
        cycle(P_NOP, 0, 0, 0);
        cycle(P_ACT, 0, 0, 0);
        // R5: full page ignores auto-precharge
        full_page = 1'b1;
        cycle(P_NOP, 0, 0, 0);
        cycle(P_RD, 0, 1, 1);
        cycle(P_NOP, 0, 0, 0);
        // R8: precharge closes open bank
        cycle(P_PRE, 0, 1, 0);
        // R6: trcd of 0 and 1 allow next-edge access
        full_page = 1'b0;
        trcd_cycles = 4'd0;
        cycle(P_ACT, 0, 1, 0);
        cycle(P_WR, 0, 1, 0);
        cycle(P_PRE, 0, 1, 0);
        trcd_cycles = 4'd1;
        cycle(P_ACT, 0, 1, 0);
        cycle(P_RD, 0, 1, 0);

        // random rounds
        for (int r = 0; r < 40; r++) begin
            trcd_cycles  = 4'($urandom_range(0, 4));
            trp_cycles   = 4'($urandom_range(1, 5));
            burst_cycles = 4'(1 << $urandom_range(0, 3));
            full_page    = ($urandom_range(0, 5) == 0);
            for (int i = 0; i < 100; i++) begin
                int k = $urandom_range(0, 9);
                logic bb = 1'($urandom);
                case (k)
                    0, 1: cycle(P_ACT, 0, bb, 0);
                    2:    cycle(P_PRE, 0, bb, 0);
                    3, 4: cycle(P_RD, 0, bb, 1'($urandom));
                    5:    cycle(P_WR, 0, bb, 0);
                    6:    cycle(3'($urandom), 1'($urandom), bb, 1'($urandom));
                    default: cycle(P_NOP, 1'($urandom), bb, 0);
                endcase
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule